// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two `W`-bit integers over several clock cycles, using one `W`-bit adder and no multiplier array. The multiplicand sits in register A. The multiplier is loaded into a low-half register MQ, and a high-half accumulator AC starts at zero. On each iteration, A is added into AC when the least significant bit of MQ is set. The whole AC:MQ pair then moves one place to the right, and the carry out of that addition drops into the top bit of AC. After `W` iterations, AC holds the upper half of the product and MQ holds the lower half.

A per-operation mode bit selects unsigned or two's-complement operands. In signed mode, both operands are first reduced to their magnitudes. The unsigned loop then runs on those magnitudes, and the 2W-bit result is negated when exactly one operand was negative.

A caller pulses `start_i` with the operands and the mode while the block is idle. It then waits for the one-cycle `done_o` pulse. The result stays on `product_o` until the next operation completes.

Top module: `seqmul`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `product_o` is 0.
- R2: A `start_i` that arrives while `busy_o` is 1 is ignored. The running operation keeps its timing and its result, and no second operation follows it.
- R3: After an accepted start (`start_i`=1 while `busy_o`=0), `busy_o` is 1 for exactly W+1 consecutive cycles.
- R4: `done_o` is 1 for exactly one cycle, namely the first cycle after `busy_o` falls. In that cycle `product_o` holds the new result.
- R5: With `signed_i`=0, `product_o` equals the full 2W-bit unsigned product of `op_a_i` and `op_b_i`. This includes zero operands and the all-ones operands.
- R6: With `signed_i`=1, `product_o` equals the 2W-bit two's-complement product. This includes operands equal to the most negative value (only bit W-1 set) and mixed signs.
- R7: `product_o` changes only in a cycle where `done_o` is 1. Otherwise it keeps the previous result, including while a following operation is running.
- R8: A 3-bit instance multiplying 3'b110 by 3'b101 in unsigned mode yields 6'b011110 (30). The upper three bits are 011 and the lower three bits are 110.
- R9: The operands and the mode are captured at the accepted start. Changing them while `busy_o` is 1 has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a multiplication; taken only while idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_a_i | input | W | Multiplicand |
| op_b_i | input | W | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse marking a fresh result |
| product_o | output | 2W | Last completed product |

## Verification
Two things can fall in the same cycle. The first is the completion pulse of one product together with the start request of the next. The bench raises `start_i` in the very cycle in which `done_o` is observed high. It then judges two things: that the previous product stays on `product_o` while the new operation is busy, and that the second result appears after exactly W+1 busy cycles. The second case is a start request during a running iteration. It is provoked in the middle of the loop with different operands, and it must leave both the busy length and the product of the first operation untouched.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/seqmul_mag.sv
module seqmul_mag #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         sgn_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    neg_o = sgn_i & val_i[W-1];
    mag_o = neg_o ? (~val_i + 1'b1) : val_i;
  end

  // R6: a signed magnitude never exceeds 2^(W-1)
  always_comb begin
    if (sgn_i) begin
      a_r6_mag_range: assert (mag_o <= MOST_NEG);
    end
  end
endmodule

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
  import seqmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    fin_o   = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_FIN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FIN: begin
        fin_o   = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  // R3: once iterating, the block stays busy in the following cycle
  a_r3_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> busy_o);

  // R4: the completion pulse lasts a single cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2: a request while busy never restarts the loop
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !(state_q == ST_RUN && cnt_q == '0));
endmodule

// File: rtl/seqmul_datapath.sv
module seqmul_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] mq_o
);
  localparam int SW = W + 1;

  logic [W-1:0]    a_q, a_d;
  logic [W-1:0]    ac_q, ac_d;
  logic [W-1:0]    mq_q, mq_d;
  logic [SW-1:0]   sum;
  logic [2*W:0]    shifted;
  logic            en;

  always_comb begin
    sum     = {1'b0, ac_q} + (mq_q[0] ? {1'b0, a_q} : '0);
    shifted = {sum, mq_q} >> 1;
    a_d     = a_q;
    ac_d    = ac_q;
    mq_d    = mq_q;
    if (load_i) begin
      a_d  = mcand_i;
      ac_d = '0;
      mq_d = mplier_i;
    end else if (step_i) begin
      ac_d = shifted[2*W-1:W];
      mq_d = shifted[W-1:0];
    end
  end

  assign en = load_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      ac_q <= '0;
      mq_q <= '0;
    end else if (en) begin
      a_q  <= a_d;
      ac_q <= ac_d;
      mq_q <= mq_d;
    end
  end

  assign ac_o = ac_q;
  assign mq_o = mq_q;

  // R5: a step with a clear multiplier bit is a pure right shift with a zero entering AC
  a_r5_noadd_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !mq_q[0]) |=> (ac_q[W-1] == 1'b0));

  // R9: the multiplicand register only changes on a load
  a_r9_mcand_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(a_q));
endmodule

// File: rtl/seqmul.sv
module seqmul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           signed_i,
  input  logic [W-1:0]   op_a_i,
  input  logic [W-1:0]   op_b_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  localparam int PW = 2 * W;

  logic           load, step, fin;
  logic [W-1:0]   mag_a, mag_b;
  logic           neg_a, neg_b;
  logic [W-1:0]   ac, mq;
  logic           flip_q, flip_d;
  logic [PW-1:0]  prod_q, prod_d;
  logic [PW-1:0]  raw;

  seqmul_ctrl #(.W(W)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .fin_o   (fin),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  seqmul_mag #(.W(W)) i_mag_a (
    .val_i (op_a_i),
    .sgn_i (signed_i),
    .mag_o (mag_a),
    .neg_o (neg_a)
  );

  seqmul_mag #(.W(W)) i_mag_b (
    .val_i (op_b_i),
    .sgn_i (signed_i),
    .mag_o (mag_b),
    .neg_o (neg_b)
  );

  seqmul_datapath #(.W(W)) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .mcand_i  (mag_a),
    .mplier_i (mag_b),
    .ac_o     (ac),
    .mq_o     (mq)
  );

  always_comb begin
    raw    = {ac, mq};
    flip_d = load ? (neg_a ^ neg_b) : flip_q;
    prod_d = flip_q ? (~raw + 1'b1) : raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip_q <= 1'b0;
    end else if (load) begin
      flip_q <= flip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (fin) begin
      prod_q <= prod_d;
    end
  end

  assign product_o = prod_q;

  // R7: the visible product only moves together with the completion pulse
  a_r7_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (product_o != $past(product_o)) |-> done_o);

  // R4: completion is reported only right after a busy cycle
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(busy_o) && !busy_o));
endmodule

// File: tb/test_seqmul.sv
module test_seqmul;
  localparam int W         = 32;
  localparam int PW        = 2 * W;
  localparam int CLK_PER   = 10;
  localparam int WATCHDOG  = 50000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           sgn = 1'b0;
  logic [W-1:0]   op_a = '0;
  logic [W-1:0]   op_b = '0;
  logic           busy, done;
  logic [PW-1:0]  product;

  logic           start3 = 1'b0;
  logic [2:0]     a3 = '0;
  logic [2:0]     b3 = '0;
  logic           busy3, done3;
  logic [5:0]     product3;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  seqmul #(.W(W)) i_seqmul (
    .clk (clk), .rst_n (rst_n), .start_i (start), .signed_i (sgn),
    .op_a_i (op_a), .op_b_i (op_b), .busy_o (busy), .done_o (done),
    .product_o (product)
  );

  seqmul #(.W(3)) i_seqmul_w3 (
    .clk (clk), .rst_n (rst_n), .start_i (start3), .signed_i (1'b0),
    .op_a_i (a3), .op_b_i (b3), .busy_o (busy3), .done_o (done3),
    .product_o (product3)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a,
                                            input logic [W-1:0] b, input logic s);
    logic [PW-1:0] ea, eb;
    ea = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  // mode 0: plain; 1: disturb inputs while busy (R9); 2: start while busy (R2)
  task automatic run_core(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic s, input int mode, input string req);
    logic [PW-1:0] exp;
    int nb;
    exp = ref_mul(a, b, s);
    @(negedge clk);
    op_a = a; op_b = b; sgn = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nb = 0;
    while (busy && nb < W + 8) begin
      nb++;
      if (mode == 1) begin
        op_a = ~a; op_b = b + 32'd7; sgn = ~s;
      end
      if (mode == 2 && nb == 4) begin
        op_a = 32'd3; op_b = 32'd5; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(nb == W + 1, "R3", "busy length", PW'(nb), PW'(W + 1));
    check(done == 1'b1, "R4", "done after busy", PW'(done), 1);
    check(product == exp, req, "product", product, exp);
    @(negedge clk);
    check(done == 1'b0, "R4", "done single cycle", PW'(done), 0);
    check(busy == 1'b0, (mode == 2) ? "R2" : "R3", "stays idle", PW'(busy), 0);
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1", "busy at reset", PW'(busy), 0);
    check(done == 1'b0, "R1", "done at reset", PW'(done), 0);
    check(product == '0, "R1", "product at reset", product, 0);
  endtask

  task automatic t_unsigned();
    run_core(32'd0, 32'hDEAD_BEEF, 1'b0, 0, "R5");
    run_core(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, "R5");
    run_core(32'd1, 32'h8000_0000, 1'b0, 0, "R5");
    run_core(32'd6, 32'd5, 1'b0, 0, "R5");
    for (int i = 0; i < 8; i++) begin
      run_core($urandom, $urandom, 1'b0, 0, "R5");
    end
  endtask

  task automatic t_signed();
    run_core(32'h8000_0000, 32'h8000_0000, 1'b1, 0, "R6");
    run_core(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 0, "R6");
    run_core(32'h8000_0000, 32'd1, 1'b1, 0, "R6");
    run_core(32'hFFFF_FFFA, 32'd7, 1'b1, 0, "R6");
    run_core(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 0, "R6");
    run_core(32'd0, 32'h8000_0000, 1'b1, 0, "R6");
    for (int i = 0; i < 8; i++) begin
      run_core($urandom, $urandom, 1'b1, 0, "R6");
    end
  endtask

  task automatic t_disturb();
    run_core(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1, "R9");
    run_core(32'hF000_0001, 32'h0000_0003, 1'b1, 1, "R9");
  endtask

  task automatic t_start_busy();
    run_core(32'h0000_FFFF, 32'h0001_0001, 1'b0, 2, "R2");
  endtask

  task automatic t_hold();
    logic [PW-1:0] held;
    held = product;
    repeat (6) @(negedge clk);
    check(product == held, "R7", "idle hold", product, held);
  endtask

  task automatic t_back_to_back();
    logic [PW-1:0] e1, e2;
    int nb;
    e1 = ref_mul(32'd1000, 32'd2000, 1'b0);
    e2 = ref_mul(32'hFFFF_FFFE, 32'd9, 1'b1);
    @(negedge clk);
    op_a = 32'd1000; op_b = 32'd2000; sgn = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nb = 0;
    while (busy && nb < W + 8) begin nb++; @(negedge clk); end
    check(done == 1'b1, "R4", "first done", PW'(done), 1);
    check(product == e1, "R5", "first product", product, e1);
    op_a = 32'hFFFF_FFFE; op_b = 32'd9; sgn = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R3", "start in done cycle accepted", PW'(busy), 1);
    check(product == e1, "R7", "old product kept while busy", product, e1);
    nb = 0;
    while (busy && nb < W + 8) begin nb++; @(negedge clk); end
    check(nb == W + 1, "R3", "second busy length", PW'(nb), PW'(W + 1));
    check(product == e2, "R6", "second product", product, e2);
  endtask

  task automatic t_small();
    int nb;
    @(negedge clk);
    a3 = 3'b110; b3 = 3'b101; start3 = 1'b1;
    @(negedge clk);
    start3 = 1'b0;
    nb = 0;
    while (busy3 && nb < 12) begin nb++; @(negedge clk); end
    check(nb == 4, "R3", "3-bit busy length", PW'(nb), 4);
    check(product3 == 6'b011110, "R8", "3-bit product", PW'(product3), PW'(30));
    check(product3[5:3] == 3'b011, "R8", "3-bit upper half", PW'(product3[5:3]), 3);
  endtask

  initial begin
    #(CLK_PER * 2 + 3);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_disturb();
    t_start_busy();
    t_hold();
    t_back_to_back();
    t_small();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule